// File: doc/BRIEF.md
# Half-Precision Augmented Adder

This block adds two binary16 floating-point operands and returns two binary16 words. The head is the sum rounded to the nearest representable value. The tail is the rounding error left over, given exactly, so that head and tail together carry the full sum with nothing lost. A halfway case always rounds toward the candidate of smaller magnitude. This rule is fixed: no mode input or global setting can change it. Software that emulates wider precision, or that needs sums reproducible bit for bit, uses the pair as a single-step two-sum.

Word layout: bit 15 is the sign, bits 14:10 hold the exponent field with bias 15, and bits 9:0 hold the stored fraction. An exponent field of 0 means zero or a subnormal. An exponent field of all ones means infinity when the fraction is zero and NaN otherwise. Both operands are converted to integer magnitudes on the grid of the smallest subnormal step. A binary16 operand then fits in 40 bits, so the exact sum is formed with no sticky-bit loss. The head is rounded from that exact sum, and the tail is the exact integer difference between the sum and the head, packed again. Both results go through one register stage.

The format is set by two parameters, `EXP_W` and `FRAC_W`. Any other setting follows the same rules.

Top module: `aug_adder`

## Requirements
- R1: `h` is `x + y` rounded to the nearest binary16 value (bit 15 sign, bits 14:10 exponent field with bias 15, bits 9:0 fraction; exponent field 0 means zero or subnormal, all ones means infinity or NaN).
- R2: When the exact sum lies halfway between two representable values, `h` takes the one of smaller magnitude, regardless of which one is even.
- R3: For finite operands whose head does not overflow, `t` is representable and `h + t` equals `x + y` exactly. A nonzero `t` has an exponent field no larger than that of `h`.
- R4: If either input is NaN, or the inputs are infinities of opposite sign, both `h` and `t` are the quiet NaN 0x7E00 (sign 0, exponent all ones, fraction MSB set).
- R5: If either input is infinite and R4 does not apply, `h` is infinity with that input's sign and `t` equals `h`.
- R6: If the rounded head exceeds the largest finite value, `h` is infinity with the sum's sign and `t` equals `h`. An exact tie between the largest finite value and the next step up rounds to the largest finite value.
- R7: When the exact sum of finite inputs is zero, `h` is +0 unless both inputs are -0, in which case it is -0. A zero `t` carries the sign of `h`.
- R8: Swapping `x` and `y` leaves `h` and `t` unchanged.
- R9: Outputs are registered. A result appears one clock edge after its operands are presented. While reset is asserted, and until its synchronized release, both outputs are 0x0000.
- R10: The same rules hold for any format chosen through `EXP_W` and `FRAC_W`. The quiet NaN is then sign 0, exponent all ones, and only the fraction MSB set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x | input | EXP_W+FRAC_W+1 (16) | First operand |
| y | input | EXP_W+FRAC_W+1 (16) | Second operand |
| h | output | EXP_W+FRAC_W+1 (16) | Head: sum rounded to nearest, ties toward zero |
| t | output | EXP_W+FRAC_W+1 (16) | Tail: exact residual of the head |

## Verification
The bench builds the block twice. One copy uses the default binary16 format. The other uses a 3-bit exponent and a 3-bit fraction, whose 128 by 128 operand pairs are swept exhaustively. In that small format every subnormal, tie, cancellation, overflow boundary and special-value pairing occurs, and the bench checks each one against exact integer arithmetic. The binary16 copy gets hand-derived tie and overflow-boundary cases plus pseudo-random pairs that mix near-cancellations and wide exponent gaps. Each random pair is applied in both orders.

// File: rtl/aug_pkg.sv
package aug_pkg;

  // operand classification after unpacking
  typedef enum logic [1:0] {
    FP_FINITE = 2'd0,
    FP_INF    = 2'd1,
    FP_NAN    = 2'd2
  } fp_cls_e;

  // width of a finite magnitude on the smallest-subnormal grid
  function automatic int mag_width(input int exp_w, input int frac_w);
    return frac_w + 1 + (1 << exp_w) - 3;
  endfunction

endpackage

// File: rtl/aug_unpack.sv
module aug_unpack
  import aug_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int MAG_W  = 40
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output fp_cls_e               cls,
  output logic [MAG_W-1:0]      mag
);

  localparam int W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  field;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   mant;
  logic [EXP_W-1:0]  shamt;

  always_comb begin
    field = word[FRAC_W +: EXP_W];
    frac  = word[FRAC_W-1:0];
    sign  = word[W-1];
    cls   = FP_FINITE;
    mant  = '0;
    shamt = '0;
    mag   = '0;
    if (&field) begin
      cls = (|frac) ? FP_NAN : FP_INF;
    end else begin
      // hidden bit is set for every nonzero field; subnormals share field 1's scale
      mant  = {|field, frac};
      shamt = (|field) ? field - EXP_W'(1) : '0;
      mag   = MAG_W'(mant) << shamt;
    end
  end

endmodule

// File: rtl/aug_exact_sum.sv
module aug_exact_sum #(
  parameter int MAG_W = 40
) (
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             s_sign,
  output logic [MAG_W:0]   s_mag
);

  logic [MAG_W:0] ext_a;
  logic [MAG_W:0] ext_b;

  assign ext_a = {1'b0, a_mag};
  assign ext_b = {1'b0, b_mag};

  always_comb begin
    if (a_sign == b_sign) begin
      s_mag  = ext_a + ext_b;
      s_sign = a_sign;
    end else if (a_mag >= b_mag) begin
      s_mag  = ext_a - ext_b;
      s_sign = a_sign;
    end else begin
      s_mag  = ext_b - ext_a;
      s_sign = b_sign;
    end
    // exact zero: negative only when both addends are negative (symmetric in a/b)
    if (s_mag == '0) begin
      s_sign = a_sign & b_sign;
    end
  end

endmodule

// File: rtl/aug_round_pack.sv
module aug_round_pack #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10,
  parameter int MAG_W  = 41
) (
  input  logic                  sign,
  input  logic [MAG_W-1:0]      mag,
  output logic [EXP_W+FRAC_W:0] word
);

  localparam int SH_W   = $clog2(MAG_W + 1);
  localparam int FLD_W  = SH_W + 1;
  localparam int MANT_W = FRAC_W + 1;
  localparam int EMAX   = (1 << EXP_W) - 1;
  localparam logic [MAG_W-1:0] ONE = MAG_W'(1);

  logic [SH_W-1:0]   msb;
  logic [SH_W-1:0]   sh;
  logic [SH_W-1:0]   sh_f;
  logic [MAG_W-1:0]  shifted;
  logic [MANT_W-1:0] q;
  logic [MAG_W-1:0]  half_mask;
  logic [MAG_W-1:0]  low_mask;
  logic              guard;
  logic              sticky;
  logic [MANT_W:0]   q_inc;
  logic [MANT_W-1:0] mant;
  logic [FLD_W-1:0]  field;
  logic              ovf;

  // leading-one position
  always_comb begin
    msb = '0;
    for (int i = 0; i < MAG_W; i++) begin
      if (mag[i]) msb = SH_W'(i);
    end
  end

  // round to nearest; a bare guard bit (exact half) is dropped: ties toward zero
  always_comb begin
    sh        = (msb > SH_W'(FRAC_W)) ? msb - SH_W'(FRAC_W) : '0;
    shifted   = mag >> sh;
    q         = shifted[MANT_W-1:0];
    half_mask = (ONE << sh) >> 1;
    low_mask  = (half_mask == '0) ? '0 : half_mask - ONE;
    guard     = |(mag & half_mask);
    sticky    = |(mag & low_mask);
    q_inc     = {1'b0, q} + {{MANT_W{1'b0}}, guard & sticky};
    if (q_inc[MANT_W]) begin
      mant = q_inc[MANT_W:1];
      sh_f = sh + SH_W'(1);
    end else begin
      mant = q_inc[MANT_W-1:0];
      sh_f = sh;
    end
    field = mant[FRAC_W] ? ({1'b0, sh_f} + FLD_W'(1)) : '0;
    ovf   = (field >= FLD_W'(EMAX));
  end

  always_comb begin
    if (ovf) begin
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else begin
      word = {sign, field[EXP_W-1:0], mant[FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/aug_rst_sync.sv
module aug_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/aug_adder.sv
module aug_adder
  import aug_pkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [EXP_W+FRAC_W:0] x,
  input  logic [EXP_W+FRAC_W:0] y,
  output logic [EXP_W+FRAC_W:0] h,
  output logic [EXP_W+FRAC_W:0] t
);

  localparam int W     = EXP_W + FRAC_W + 1;
  localparam int MAG_W = mag_width(EXP_W, FRAC_W);
  localparam int SUM_W = MAG_W + 1;
  localparam logic [W-1:0] QNAN    = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic rst_n_sync;

  aug_rst_sync u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_sync)
  );

  // operand unpacking
  logic [W-1:0]     op_word [2];
  logic             op_sign [2];
  fp_cls_e          op_cls  [2];
  logic [MAG_W-1:0] op_mag  [2];

  assign op_word[0] = x;
  assign op_word[1] = y;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    aug_unpack #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W),
      .MAG_W (MAG_W)
    ) u_unpack (
      .word(op_word[g]),
      .sign(op_sign[g]),
      .cls (op_cls[g]),
      .mag (op_mag[g])
    );
  end

  // exact sum on the subnormal grid
  logic             s_sign;
  logic [SUM_W-1:0] s_mag;

  aug_exact_sum #(
    .MAG_W(MAG_W)
  ) u_sum (
    .a_sign(op_sign[0]),
    .a_mag (op_mag[0]),
    .b_sign(op_sign[1]),
    .b_mag (op_mag[1]),
    .s_sign(s_sign),
    .s_mag (s_mag)
  );

  // head rounding
  logic [W-1:0] head_word;

  aug_round_pack #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .MAG_W (SUM_W)
  ) u_head (
    .sign(s_sign),
    .mag (s_mag),
    .word(head_word)
  );

  // head magnitude back on the grid, for the residual
  logic             hd_sign;
  fp_cls_e          hd_cls;
  logic [SUM_W-1:0] hd_mag;

  aug_unpack #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .MAG_W (SUM_W)
  ) u_head_mag (
    .word(head_word),
    .sign(hd_sign),
    .cls (hd_cls),
    .mag (hd_mag)
  );

  // residual and tail packing (exact, rounding never engages)
  logic             res_sign;
  logic [SUM_W-1:0] res_mag;
  logic [W-1:0]     tail_word;

  always_comb begin
    if (s_mag >= hd_mag) begin
      res_mag  = s_mag - hd_mag;
      res_sign = hd_sign;
    end else begin
      res_mag  = hd_mag - s_mag;
      res_sign = ~hd_sign;
    end
  end

  aug_round_pack #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .MAG_W (SUM_W)
  ) u_tail (
    .sign(res_sign),
    .mag (res_mag),
    .word(tail_word)
  );

  // special-value selection
  logic         any_nan;
  logic         any_inf;
  logic         inf_sign;
  logic [W-1:0] h_d;
  logic [W-1:0] t_d;

  always_comb begin
    any_inf  = (op_cls[0] == FP_INF) || (op_cls[1] == FP_INF);
    any_nan  = (op_cls[0] == FP_NAN) || (op_cls[1] == FP_NAN) ||
               ((op_cls[0] == FP_INF) && (op_cls[1] == FP_INF) && (op_sign[0] != op_sign[1]));
    inf_sign = (op_cls[0] == FP_INF) ? op_sign[0] : op_sign[1];
    if (any_nan) begin
      h_d = QNAN;
      t_d = QNAN;
    end else if (any_inf) begin
      h_d = {inf_sign, INF_MAG};
      t_d = {inf_sign, INF_MAG};
    end else if (hd_cls != FP_FINITE) begin
      h_d = head_word;
      t_d = head_word;
    end else begin
      h_d = head_word;
      t_d = tail_word;
    end
  end

  // output register
  logic [W-1:0] h_q;
  logic [W-1:0] t_q;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      h_q <= '0;
      t_q <= '0;
    end else begin
      h_q <= h_d;
      t_q <= t_d;
    end
  end

  assign h = h_q;
  assign t = t_q;

endmodule

// File: rtl/aug_adder_chk.sv
module aug_adder_chk #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [EXP_W+FRAC_W:0] x,
  input logic [EXP_W+FRAC_W:0] y,
  input logic [EXP_W+FRAC_W:0] h,
  input logic [EXP_W+FRAC_W:0] t
);

  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic x_nan, y_nan, x_inf, y_inf, x_zero, y_zero;
  logic h_spec, t_spec, t_zero, h_inf;
  logic primed;

  assign x_nan  = (&x[FRAC_W +: EXP_W]) & (|x[FRAC_W-1:0]);
  assign y_nan  = (&y[FRAC_W +: EXP_W]) & (|y[FRAC_W-1:0]);
  assign x_inf  = (&x[FRAC_W +: EXP_W]) & ~(|x[FRAC_W-1:0]);
  assign y_inf  = (&y[FRAC_W +: EXP_W]) & ~(|y[FRAC_W-1:0]);
  assign x_zero = (x[W-2:0] == '0);
  assign y_zero = (y[W-2:0] == '0);
  assign h_spec = &h[FRAC_W +: EXP_W];
  assign t_spec = &t[FRAC_W +: EXP_W];
  assign t_zero = (t[W-2:0] == '0);
  assign h_inf  = h_spec & ~(|h[FRAC_W-1:0]);

  // set one edge after reset release, so $past refers to a captured operand
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assert_nan_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(x_nan || y_nan)) |-> (h == QNAN && t == QNAN));

  assert_inf_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past((x_inf || y_inf) && !x_nan && !y_nan &&
                     !(x_inf && y_inf && (x[W-1] != y[W-1]))))
    |-> (h_inf && t == h));

  assert_tail_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_spec && !t_zero) |-> (!t_spec && (t[FRAC_W +: EXP_W] <= h[FRAC_W +: EXP_W])));

  assert_inf_head_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
    h_inf |-> (t == h));

  assert_zero_tail_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (t_zero && !h_spec) |-> (t[W-1] == h[W-1]));

  assert_zero_inputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(x_zero && y_zero))
    |-> (h == {$past(x[W-1] & y[W-1]), {(W-1){1'b0}}} && t == h));

endmodule

bind aug_adder aug_adder_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk  (clk),
  .rst_n(rst_n_sync),
  .x    (x),
  .y    (y),
  .h    (h),
  .t    (t)
);

// File: tb/aug_adder_tb.sv
module aug_adder_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] x16, y16, h16, t16;
  logic [6:0]  xs, ys, hs, ts;

  int checks;
  int fails;
  logic [31:0] rs;

  aug_adder u_dut (
    .clk(clk), .rst_n(rst_n), .x(x16), .y(y16), .h(h16), .t(t16)
  );

  aug_adder #(.EXP_W(3), .FRAC_W(3)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .x(xs), .y(ys), .h(hs), .t(ts)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic dec(input int ew, input int fw, input longint w,
                     output int sgn, output int cls, output longint mag);
    longint fld, frac;
    fld  = (w >> fw) & ((longint'(1) << ew) - 1);
    frac = w & ((longint'(1) << fw) - 1);
    sgn  = int'((w >> (ew + fw)) & 1);
    cls  = 0;
    mag  = 0;
    if (fld == (longint'(1) << ew) - 1) cls = (frac != 0) ? 2 : 1;
    else if (fld == 0) mag = frac;
    else mag = (frac | (longint'(1) << fw)) << (fld - 1);
  endtask

  function automatic longint enc(input int ew, input int fw, input int sgn, input longint m,
                                 output bit ovf, output bit tie);
    longint q, rem, half, fld, fmask;
    int k, sh;
    ovf   = 1'b0;
    tie   = 1'b0;
    fmask = (longint'(1) << fw) - 1;
    if (m == 0) return longint'(sgn) << (ew + fw);
    k = 0;
    for (int i = 0; i < 62; i++) if (m[i]) k = i;
    if (k <= fw) begin
      fld = (m >> fw) & 1;
      q   = m;
    end else begin
      sh   = k - fw;
      q    = m >> sh;
      rem  = m - (q << sh);
      half = longint'(1) << (sh - 1);
      tie  = (rem == half);
      if (rem > half) q = q + 1;
      if (q == (longint'(1) << (fw + 1))) begin
        q  = q >> 1;
        sh = sh + 1;
      end
      fld = sh + 1;
    end
    if (fld >= (longint'(1) << ew) - 1) begin
      ovf = 1'b1;
      return (longint'(sgn) << (ew + fw)) | (((longint'(1) << ew) - 1) << fw);
    end
    return (longint'(sgn) << (ew + fw)) | (fld << fw) | (q & fmask);
  endfunction

  // exact-arithmetic reference
  task automatic ref_model(input int ew, input int fw, input longint xw, input longint yw,
                           output longint hw, output longint tw,
                           output string tag_h, output string tag_t);
    int sx, sy, cx, cy, hsg, tsg, dsg, dcl;
    longint mx, my, s, m, hm, tv, emaxf, qnan, infw;
    bit ovf, tie, ovf2, tie2;
    int top;
    top   = ew + fw;
    emaxf = (longint'(1) << ew) - 1;
    qnan  = (emaxf << fw) | (longint'(1) << (fw - 1));
    infw  = emaxf << fw;
    dec(ew, fw, xw, sx, cx, mx);
    dec(ew, fw, yw, sy, cy, my);
    if (cx == 2 || cy == 2 || (cx == 1 && cy == 1 && sx != sy)) begin
      hw = qnan; tw = qnan; tag_h = "R4"; tag_t = "R4";
    end else if (cx == 1 || cy == 1) begin
      hsg = (cx == 1) ? sx : sy;
      hw = (longint'(hsg) << top) | infw; tw = hw; tag_h = "R5"; tag_t = "R5";
    end else begin
      s = (sx != 0 ? -mx : mx) + (sy != 0 ? -my : my);
      if (s == 0) begin
        hsg = sx & sy;
        hw = longint'(hsg) << top; tw = hw; tag_h = "R7"; tag_t = "R7";
      end else begin
        hsg = (s < 0) ? 1 : 0;
        m   = (s < 0) ? -s : s;
        hw  = enc(ew, fw, hsg, m, ovf, tie);
        if (ovf) begin
          tw = hw; tag_h = "R6"; tag_t = "R6";
        end else begin
          dec(ew, fw, hw, dsg, dcl, hm);
          tv  = m - hm;
          tsg = (tv < 0) ? 1 - hsg : hsg;
          if (tv == 0) tw = longint'(hsg) << top;
          else tw = enc(ew, fw, tsg, (tv < 0) ? -tv : tv, ovf2, tie2);
          tag_h = tie ? "R2" : "R1";
          tag_t = tie ? "R2" : "R3";
        end
      end
    end
  endtask

  task automatic run16(input logic [15:0] a, input logic [15:0] b);
    longint eh, et;
    string th, tt;
    ref_model(5, 10, longint'(a), longint'(b), eh, et, th, tt);
    x16 = a; y16 = b;
    @(negedge clk);
    check(th, "h16", longint'(h16), eh);
    check(tt, "t16", longint'(t16), et);
  endtask

  // hand-derived binary16 vector
  task automatic directed(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] eh, input logic [15:0] et);
    x16 = a; y16 = b;
    @(negedge clk);
    check(req, "h16 directed", longint'(h16), longint'(eh));
    check(req, "t16 directed", longint'(t16), longint'(et));
  endtask

  function automatic logic [15:0] nxt16();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs[15:0];
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] a, b, h1, t1;
    longint eh, et;
    string th, tt;
    checks = 0;
    fails  = 0;
    rs     = 32'h1234_5678;
    rst_n  = 1'b0;
    x16 = 16'h3C00; y16 = 16'h3C00; xs = 7'h1A; ys = 7'h1A;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero while reset is asserted, inputs notwithstanding
    check("R9", "h16 in reset", longint'(h16), 0);
    check("R9", "t16 in reset", longint'(t16), 0);
    check("R9", "hs in reset", longint'(hs), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    directed("R2", 16'h3C01, 16'h1000, 16'h3C01, 16'h1000);  // tie, even would be 0x3C02
    directed("R2", 16'hBC01, 16'h9000, 16'hBC01, 16'h9000);  // negative tie
    directed("R1", 16'h3C00, 16'h1001, 16'h3C01, 16'h8FFE);  // above half rounds up
    directed("R3", 16'h3C00, 16'h0001, 16'h3C00, 16'h0001);  // smallest subnormal kept in tail
    directed("R6", 16'h7BFF, 16'h4C00, 16'h7BFF, 16'h4C00);  // tie at overflow boundary
    directed("R6", 16'h7BFF, 16'h4C01, 16'h7C00, 16'h7C00);  // overflow
    directed("R5", 16'hFC00, 16'h3C00, 16'hFC00, 16'hFC00);
    directed("R4", 16'h7C00, 16'hFC00, 16'h7E00, 16'h7E00);
    directed("R4", 16'h7D00, 16'h3C00, 16'h7E00, 16'h7E00);
    directed("R7", 16'h3C00, 16'hBC00, 16'h0000, 16'h0000);
    directed("R7", 16'h8000, 16'h8000, 16'h8000, 16'h8000);
    directed("R7", 16'h8000, 16'h0000, 16'h0000, 16'h0000);

    // R9: new operands do not reach the outputs before the next edge
    x16 = 16'h3C00; y16 = 16'h3C00;
    #1;
    check("R9", "h16 before edge", longint'(h16), 16'h0000);
    @(negedge clk);
    check("R9", "h16 after one edge", longint'(h16), 16'h4000);
    check("R1", "t16 exact doubling", longint'(t16), 16'h0000);

    // R10: exhaustive sweep of the 3-bit exponent / 3-bit fraction format
    for (int i = 0; i < 128; i++) begin
      for (int j = 0; j < 128; j++) begin
        xs = 7'(i); ys = 7'(j);
        ref_model(3, 3, longint'(i), longint'(j), eh, et, th, tt);
        @(negedge clk);
        if (longint'(hs) != eh) check({th, "/R10"}, "hs", longint'(hs), eh);
        else check(th, "hs", longint'(hs), eh);
        if (longint'(ts) != et) check({tt, "/R10"}, "ts", longint'(ts), et);
        else check(tt, "ts", longint'(ts), et);
      end
    end

    // binary16 random pairs, both orders (R8)
    for (int n = 0; n < 10000; n++) begin
      a = nxt16();
      if (n % 2 == 0) b = nxt16();
      else b = (a ^ {8'h00, nxt16() & 16'h00FF}[15:0]) ^ 16'h8000;
      run16(a, b);
      h1 = h16; t1 = t16;
      x16 = b; y16 = a;
      @(negedge clk);
      check("R8", "h16 swapped", longint'(h16), longint'(h1));
      check("R8", "t16 swapped", longint'(t16), longint'(t1));
    end

    summary();
    $finish;
  end

endmodule